// File: doc/BRIEF.md
# CAN bus-off recovery sequencer

This block takes a CAN node through its return from the Bus_Off state. A pulse on `enterBusOff` from the error logic forces the initialization flag high and raises the Bus_Off status. From then on no recovery progress is made until software clears the initialization flag. After that clear, the block watches the sampled receive bit on each bit-time strobe. It counts runs of eleven consecutive recessive bits, and a bus-idle detection is one such run. Recovery ends after the 129th run.

Each completed run does three things. It advances the receive error counter, which serves as the run counter while the node is off the bus. It pulses a last-error-code write strobe and loads the Bit0Error code into the last-error-code output, so software can see whether the bus is stuck dominant or keeps being disturbed. When the final run completes, the block pulses a reset strobe for both error counters, clears the run counter and drops the Bus_Off status, all on the same clock edge. Writing the initialization flag during recovery changes only the flag, so the 129-run wait cannot be cut short.

Top module: `boff_recovery`

## Requirements
- R1: After reset, initFlag=0, busOff=0, recErrCnt=0, lecWr=0, errCntRst=0, and lecCode=3'b111 (the no-change code).
- R2: While busOff=0, a pulse on enterBusOff makes initFlag=1 and busOff=1 at the next clock edge, with recErrCnt=0.
- R3: Before software clears the initialization flag after a Bus_Off entry, receive bits are not counted: recErrCnt stays 0, lecWr stays 0 and lecCode stays 3'b111. A swInitSet pulse in this phase leaves initFlag=1 and busOff=1. The same holds for receive bits while busOff=0.
- R4: Once software has cleared the flag, every run of RUN_LEN (11) consecutive recessive bits (rxBit=1 with bitTick=1) increments recErrCnt by one. It also produces exactly one single-cycle lecWr pulse, on the edge that samples the last bit of the run, and sets lecCode to 3'b101 (Bit0Error).
- R5: A dominant bit (rxBit=0 with bitTick=1) during recovery restarts the current run from zero and leaves recErrCnt unchanged. After 128 runs, a dominant bit keeps busOff=1.
- R6: A cycle with bitTick=0 has no effect on recovery progress, whatever the value of rxBit.
- R7: On the edge that completes run number RUN_COUNT (129), busOff goes to 0, errCntRst pulses for one cycle, recErrCnt returns to 0 and lecWr pulses.
- R8: During recovery, swInitSet sets initFlag and swInitClr clears it. Neither changes recErrCnt or the progress of the current run, and busOff stays 1 until run RUN_COUNT completes.
- R9: While busOff=0, swInitSet sets initFlag and swInitClr clears it. When both arrive in the same cycle, the set wins.
- R10: A pulse on enterBusOff while busOff=1 has no effect on recErrCnt or on run progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | Bit-time strobe qualifying rxBit |
| rxBit | input | 1 | Sampled receive bit, 1 = recessive |
| enterBusOff | input | 1 | Pulse from error logic: node goes Bus_Off |
| swInitSet | input | 1 | Software write strobe setting the initialization flag |
| swInitClr | input | 1 | Software write strobe clearing the initialization flag |
| initFlag | output | 1 | Initialization flag |
| busOff | output | 1 | Bus_Off status |
| recErrCnt | output | CNT_W (8) | Receive error counter, run count during recovery |
| lecWr | output | 1 | Last-error-code write strobe |
| lecCode | output | 3 | Last error code (3'b111 no change, 3'b101 Bit0Error) |
| errCntRst | output | 1 | One-cycle reset strobe for both error counters |

## Verification
The assertions assume that bitTick strobes are at least one cycle apart in effect, so two run completions never fall on adjacent edges. They also assume that enterBusOff is a single-cycle pulse from logic that knows the node state. The stimulus follows every bit strobe with an idle cycle and drives software and bus-off pulses one cycle wide between strobes, so these assumptions always hold. Under them, the run counter can only move on a strobed edge, it never passes RUN_COUNT-1, and Bus_Off can only be left together with the counter reset strobe.

// File: rtl/boff_pkg.sv
package boff_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_WAIT    = 2'd1,
    ST_RECOVER = 2'd2
  } boffState_t;

  typedef struct packed {
    logic clrCounts;
    logic countEn;
  } dpCtrl_t;

  localparam logic [2:0] LEC_NOCHG = 3'b111;
  localparam logic [2:0] LEC_BIT0  = 3'b101;
endpackage

// File: rtl/boff_dp.sv
module boff_dp
  import boff_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 129,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             rxBit,
  input  dpCtrl_t          ctrl,
  output logic             runDone,
  output logic             lastRun,
  output logic [CNT_W-1:0] recErrCnt,
  output logic             lecWr,
  output logic [2:0]       lecCode,
  output logic             errCntRst
);
  localparam int BIT_W = $clog2(RUN_LEN + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_COUNT - 1);

  logic [BIT_W-1:0] bitCnt;
  logic             strobedBit;

  assign strobedBit = ctrl.countEn && bitTick;
  assign runDone    = strobedBit && rxBit && (bitCnt == BIT_LAST);
  assign lastRun    = (recErrCnt == RUN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      recErrCnt <= '0;
    end else if (ctrl.clrCounts) begin
      bitCnt    <= '0;
      recErrCnt <= '0;
    end else if (strobedBit) begin
      if (!rxBit) begin
        bitCnt <= '0;
      end else if (bitCnt == BIT_LAST) begin
        bitCnt    <= '0;
        recErrCnt <= lastRun ? '0 : recErrCnt + CNT_W'(1);
      end else begin
        bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lecWr     <= 1'b0;
      lecCode   <= LEC_NOCHG;
      errCntRst <= 1'b0;
    end else begin
      lecWr     <= runDone;
      errCntRst <= runDone && lastRun;
      if (runDone) lecCode <= LEC_BIT0;
    end
  end
endmodule

// File: rtl/boff_ctrl.sv
module boff_ctrl
  import boff_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enterBusOff,
  input  logic    swInitSet,
  input  logic    swInitClr,
  input  logic    runDone,
  input  logic    lastRun,
  output dpCtrl_t ctrl,
  output logic    initFlag,
  output logic    busOff
);
  boffState_t state, stateNxt;
  logic       initNxt;
  logic       swRelease;

  assign swRelease = swInitClr && !swInitSet;

  always_comb begin
    stateNxt       = state;
    initNxt        = initFlag;
    ctrl.countEn   = (state == ST_RECOVER);
    ctrl.clrCounts = 1'b0;
    unique case (state)
      ST_NORMAL: begin
        if (enterBusOff) begin
          stateNxt       = ST_WAIT;
          initNxt        = 1'b1;
          ctrl.clrCounts = 1'b1;
        end else if (swInitSet) begin
          initNxt = 1'b1;
        end else if (swInitClr) begin
          initNxt = 1'b0;
        end
      end
      ST_WAIT: begin
        if (swRelease) begin
          stateNxt       = ST_RECOVER;
          initNxt        = 1'b0;
          ctrl.clrCounts = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (swInitSet)      initNxt = 1'b1;
        else if (swInitClr) initNxt = 1'b0;
        if (runDone && lastRun) stateNxt = ST_NORMAL;
      end
      default: stateNxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_NORMAL;
      initFlag <= 1'b0;
      busOff   <= 1'b0;
    end else begin
      state    <= stateNxt;
      initFlag <= initNxt;
      busOff   <= (stateNxt != ST_NORMAL);
    end
  end
endmodule

// File: rtl/boff_recovery.sv
module boff_recovery
  import boff_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 129,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             rxBit,
  input  logic             enterBusOff,
  input  logic             swInitSet,
  input  logic             swInitClr,
  output logic             initFlag,
  output logic             busOff,
  output logic [CNT_W-1:0] recErrCnt,
  output logic             lecWr,
  output logic [2:0]       lecCode,
  output logic             errCntRst
);
  dpCtrl_t ctrl;
  logic    runDone;
  logic    lastRun;

  boff_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enterBusOff(enterBusOff),
    .swInitSet  (swInitSet),
    .swInitClr  (swInitClr),
    .runDone    (runDone),
    .lastRun    (lastRun),
    .ctrl       (ctrl),
    .initFlag   (initFlag),
    .busOff     (busOff)
  );

  boff_dp #(
    .RUN_LEN  (RUN_LEN),
    .RUN_COUNT(RUN_COUNT),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .rxBit    (rxBit),
    .ctrl     (ctrl),
    .runDone  (runDone),
    .lastRun  (lastRun),
    .recErrCnt(recErrCnt),
    .lecWr    (lecWr),
    .lecCode  (lecCode),
    .errCntRst(errCntRst)
  );
endmodule

// File: rtl/boff_chk.sv
module boff_chk #(
  parameter int RUN_COUNT = 129,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitTick,
  input logic             enterBusOff,
  input logic             initFlag,
  input logic             busOff,
  input logic [CNT_W-1:0] recErrCnt,
  input logic             lecWr,
  input logic [2:0]       lecCode,
  input logic             errCntRst
);
  // R2
  enter_sets_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    enterBusOff && !busOff |=> busOff && initFlag);

  // R4
  lec_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    lecWr |-> lecCode == 3'b101);

  // R4
  run_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    lecWr && busOff |-> recErrCnt == $past(recErrCnt) + CNT_W'(1));

  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOff && !bitTick |=> $stable(recErrCnt));

  // R7
  leave_with_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> errCntRst && lecWr && recErrCnt == '0);

  // R7
  reset_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCntRst |-> $past(recErrCnt) == CNT_W'(RUN_COUNT - 1));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    recErrCnt <= CNT_W'(RUN_COUNT - 1));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lecWr |=> !lecWr);
endmodule

bind boff_recovery boff_chk #(
  .RUN_COUNT(RUN_COUNT),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bitTick    (bitTick),
  .enterBusOff(enterBusOff),
  .initFlag   (initFlag),
  .busOff     (busOff),
  .recErrCnt  (recErrCnt),
  .lecWr      (lecWr),
  .lecCode    (lecCode),
  .errCntRst  (errCntRst)
);

// File: tb/sim_boff_recovery.sv
module sim_boff_recovery;
  localparam int RUN_LEN   = 11;
  localparam int RUN_COUNT = 129;
  localparam int CNT_W     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, rxBit = 1'b1, enterBusOff = 1'b0;
  logic swInitSet = 1'b0, swInitClr = 1'b0;
  logic initFlag, busOff, lecWr, errCntRst;
  logic [CNT_W-1:0] recErrCnt;
  logic [2:0] lecCode;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int expRuns = 0;
  int pulses;
  logic sLec, sRst;

  always #5 clk = ~clk;

  boff_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxBit(rxBit),
    .enterBusOff(enterBusOff), .swInitSet(swInitSet), .swInitClr(swInitClr),
    .initFlag(initFlag), .busOff(busOff), .recErrCnt(recErrCnt),
    .lecWr(lecWr), .lecCode(lecCode), .errCntRst(errCntRst)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobed bit, then one idle cycle; sLec/sRst hold outputs of the strobed edge
  task automatic tickBit(input logic rx);
    @(negedge clk);
    bitTick = 1'b1;
    rxBit   = rx;
    @(negedge clk);
    sLec    = lecWr;
    sRst    = errCntRst;
    if (lecWr) pulses++;
    bitTick = 1'b0;
    rxBit   = ~rx;
    @(negedge clk);
  endtask

  task automatic pulseSet(); @(negedge clk); swInitSet = 1'b1; @(negedge clk); swInitSet = 1'b0; endtask
  task automatic pulseClr(); @(negedge clk); swInitClr = 1'b1; @(negedge clk); swInitClr = 1'b0; endtask
  task automatic pulseEnter(); @(negedge clk); enterBusOff = 1'b1; @(negedge clk); enterBusOff = 1'b0; endtask

  task automatic fullRun(input string req);
    pulses = 0;
    for (int b = 0; b < RUN_LEN; b++) tickBit(1'b1);
    expRuns++;
    check({req, " lecWr pulses per run"}, pulses, 1);
    check({req, " lecWr on last bit"}, int'(sLec), 1);
    check({req, " run count"}, int'(recErrCnt), expRuns);
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 initFlag", int'(initFlag), 0);
    check("R1 busOff", int'(busOff), 0);
    check("R1 recErrCnt", int'(recErrCnt), 0);
    check("R1 lecCode", int'(lecCode), 7);
    check("R1 strobes", int'({lecWr, errCntRst}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release lecCode", int'(lecCode), 7);

    // R9 software control in normal mode
    pulseSet(); check("R9 set", int'(initFlag), 1);
    pulseClr(); check("R9 clear", int'(initFlag), 0);
    @(negedge clk); swInitSet = 1'b1; swInitClr = 1'b1;
    @(negedge clk); swInitSet = 1'b0; swInitClr = 1'b0;
    check("R9 set wins", int'(initFlag), 1);
    pulseClr(); check("R9 clear again", int'(initFlag), 0);

    // R3 bits ignored while not in bus-off
    pulses = 0;
    for (int b = 0; b < 3 * RUN_LEN; b++) tickBit(1'b1);
    check("R3 normal no count", int'(recErrCnt), 0);
    check("R3 normal no lecWr", pulses, 0);
    check("R3 normal lecCode", int'(lecCode), 7);

    // R2 entry
    pulseEnter();
    check("R2 initFlag", int'(initFlag), 1);
    check("R2 busOff", int'(busOff), 1);
    check("R2 recErrCnt", int'(recErrCnt), 0);

    // R3 waiting for software
    pulses = 0;
    for (int b = 0; b < 3 * RUN_LEN; b++) tickBit(1'b1);
    check("R3 wait no count", int'(recErrCnt), 0);
    check("R3 wait no lecWr", pulses, 0);
    check("R3 wait lecCode", int'(lecCode), 7);
    pulseSet();
    check("R3 set in wait initFlag", int'(initFlag), 1);
    check("R3 set in wait busOff", int'(busOff), 1);

    pulseClr();
    check("R8 release clears initFlag", int'(initFlag), 0);

    // R6 recessive level without strobe
    @(negedge clk); rxBit = 1'b1;
    repeat (5 * RUN_LEN) @(negedge clk);
    check("R6 no strobe no count", int'(recErrCnt), 0);
    check("R6 no strobe no lecWr", int'(lecWr), 0);

    // R5 sweep of every partial-run length followed by a dominant bit
    for (int k = 1; k < RUN_LEN; k++) begin
      for (int b = 0; b < k; b++) tickBit(1'b1);
      tickBit(1'b0);
      check($sformatf("R5 partial %0d", k), int'(recErrCnt), 0);
    end

    fullRun("R4 first run");
    check("R4 lecCode", int'(lecCode), 5);
    for (int r = 1; r < 64; r++) fullRun("R4");

    // R8 init pulses mid-run leave progress alone
    for (int b = 0; b < 5; b++) tickBit(1'b1);
    pulseSet();
    check("R8 set during recovery", int'(initFlag), 1);
    check("R8 count unchanged by set", int'(recErrCnt), expRuns);
    pulseClr();
    check("R8 clear during recovery", int'(initFlag), 0);
    check("R8 count unchanged by clear", int'(recErrCnt), expRuns);
    pulses = 0;
    for (int b = 5; b < RUN_LEN; b++) tickBit(1'b1);
    expRuns++;
    check("R8 run completes after pulses", int'(recErrCnt), expRuns);
    check("R8 busOff held", int'(busOff), 1);

    while (expRuns < RUN_COUNT - 1) fullRun("R4 tail");

    // R5 dominant after 128 runs
    for (int b = 0; b < RUN_LEN - 1; b++) tickBit(1'b1);
    tickBit(1'b0);
    check("R5 stay busOff at 128", int'(busOff), 1);
    check("R5 count at 128", int'(recErrCnt), RUN_COUNT - 1);

    // R10 entry pulse while off the bus
    for (int b = 0; b < 4; b++) tickBit(1'b1);
    pulseEnter();
    check("R10 count unchanged", int'(recErrCnt), RUN_COUNT - 1);
    pulses = 0;
    for (int b = 4; b < RUN_LEN; b++) tickBit(1'b1);

    // R7 completion edge
    check("R7 errCntRst pulse", int'(sRst), 1);
    check("R7 lecWr on final run", int'(sLec), 1);
    check("R7 busOff cleared", int'(busOff), 0);
    check("R7 count reset", int'(recErrCnt), 0);
    check("R7 errCntRst single cycle", int'(errCntRst), 0);
    check("R7 initFlag kept", int'(initFlag), 0);

    // second entry starts cleanly
    pulseEnter();
    check("R2 re-entry busOff", int'(busOff), 1);
    check("R2 re-entry count", int'(recErrCnt), 0);
    pulseClr();
    expRuns = 0;
    fullRun("R4 second sequence");

    finishUp();
  end
endmodule